// File: doc/BRIEF.md
# Serial FRAM Block Transfer Engine

This block is an SPI master (clock mode 0) that moves a block of bytes between a host and a serial nonvolatile RAM. The host presents a start address, a byte count and a direction in one request handshake. For a write, the data bytes then arrive one by one on a valid/ready stream. For a read, the captured bytes leave as one-cycle pulses on a data output. A done pulse carries the number of bytes moved. The device side has a serial clock, a data-out line, a data-in line and an active-low chip select.

A write always takes two chip-select windows. The first carries only the write-enable opcode. Chip select then stays high for a programmable number of clocks. The second window carries the write opcode, the address and the data. A read takes one window: the read opcode, the address, then the requested number of bytes clocked in. The address is sent high byte first and is cut to a configured number of bytes. A small device with a single address byte and more than 256 locations uses a compact scheme: address bit 8 travels inside the opcode.

The controller is a state machine. Its states and transitions are:
- IDLE goes to WREN on a write request with a nonzero count, to OPC on a read request with a nonzero count, and to DONE when the count is zero.
- WREN goes to GAP when its byte ends.
- GAP goes to OPC after the programmed idle time.
- OPC goes to ADDR when the opcode byte ends.
- ADDR goes to WDATA or RDATA after the last address byte.
- WDATA and RDATA go to DONE after the last data byte.
- DONE always returns to IDLE.

Top module: `fram_link`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, busy and done are low and the request ready is high.
- R2: Every byte is shifted most significant bit first in clock mode 0. The serial clock idles low. Data in is sampled on the rising edge. Data out holds steady while the clock is high. Within a byte, rising edges are 2*CLK_DIV system clocks apart.
- R3: A write starts with a chip-select window that holds exactly one byte, 0x06.
- R4: Between the write-enable window and the write window, chip select stays high for at least CS_GAP system clocks.
- R5: The write window carries opcode 0x02, then the ADDR_BYTES lowest address bytes with the most significant first, then the data bytes in stream order. Chip select rises only after the last data byte.
- R6: A read uses a single window: opcode 0x03, the address bytes as in R5, then COUNT bytes whose captured values appear in order on the read data output. No write-enable byte is sent.
- R7: Compact addressing applies when DEV_SIZE > 256 and ADDR_BYTES == 1. In that mode, opcode bit 3 (value 0x08) is set when the address exceeds 0xFF, and the single address byte is address bits 7:0. Otherwise bit 3 is never set.
- R8: The edge that accepts a request raises busy and drops request ready. Busy stays high until the transfer ends.
- R9: Each request yields exactly one done pulse, with done_count equal to the requested count. Busy is low in the cycle after the pulse.
- R10: A request with a count of zero produces a done pulse without ever pulling chip select low.
- R11: During a write, a data byte is taken only on a cycle with both write valid and write ready high. While write valid is low, chip select stays low and the serial clock does not toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted (controller idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Start address in the device |
| req_len | input | LEN_W | Number of bytes to move |
| wr_valid | input | 1 | Write data byte offered |
| wr_ready | output | 1 | Write data byte taken this cycle if valid |
| wr_data | input | 8 | Write data byte |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds a read byte |
| rd_data | output | 8 | Read data byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| done_count | output | LEN_W | Bytes moved, valid with done |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The hardest case to reach from the ports is a write that has already sent its opcode and address but has no data yet. In that state chip select must stay low and the clock must stay still. The bench holds write valid low from the start of a write. It waits long enough for the address bytes to finish, counts serial clock edges over a further stretch, and only then releases the stream. The compact-address boundary is reached by running a second instance, with one address byte and a 512-byte device, at addresses 0xFF, 0x100 and 0x1FF. A device model checks every window: its byte content, the gap between windows and the spacing of clock edges.

// File: rtl/fram_pkg.sv
package fram_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WREN,
        ST_GAP,
        ST_OPC,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_DONE
    } fram_state_e;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_HIBIT = 8'h08;
endpackage

// File: rtl/fram_byte_shift.sv
module fram_byte_shift #(
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       idle,
    output logic       done,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx
);
    localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    logic          active;
    logic [DW-1:0] div;
    logic [2:0]    bitn;
    logic [7:0]    sh;
    logic [7:0]    rx_q;
    logic          sclk_q;
    logic          done_q;
    logic          tick;

    assign tick = (div == DW'(CLK_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            div    <= '0;
            bitn   <= '0;
            sh     <= '0;
            rx_q   <= '0;
            sclk_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!active) begin
                div    <= '0;
                sclk_q <= 1'b0;
                if (start) begin
                    active <= 1'b1;
                    sh     <= tx;
                    bitn   <= '0;
                end
            end else if (!tick) begin
                div <= div + 1'b1;
            end else begin
                div <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx_q   <= {rx_q[6:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    if (bitn == 3'd7) begin
                        active <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bitn <= bitn + 1'b1;
                        sh   <= {sh[6:0], 1'b0};
                    end
                end
            end
        end
    end

    assign idle = !active;
    assign done = done_q;
    assign sclk = sclk_q;
    assign mosi = active ? sh[7] : 1'b0;
    assign rx   = rx_q;

    // R2: data out must not move while the clock is high
    a_r2_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));
    // R2: a byte ends on a falling clock edge
    a_r2_end_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(sclk) && !sclk));
endmodule

// File: rtl/fram_cmd_build.sv
module fram_cmd_build
    import fram_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int ADDR_BYTES = 2,
    parameter int DEV_SIZE   = 65536
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    input  logic [1:0]        idx,
    output logic [7:0]        opcode,
    output logic [7:0]        abyte
);
    localparam bit COMPACT = (DEV_SIZE > 256) && (ADDR_BYTES == 1);

    logic [31:0] a32;
    logic [7:0]  base;

    assign a32  = 32'(addr);
    assign base = is_write ? OP_WRITE : OP_READ;

    generate
        if (COMPACT) begin : g_compact
            assign opcode = base | ((|a32[31:8]) ? OP_HIBIT : 8'h00);
        end else begin : g_plain
            assign opcode = base;
        end
    endgenerate

    assign abyte = a32[{idx, 3'b000} +: 8];
endmodule

// File: rtl/fram_link.sv
module fram_link
    import fram_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int LEN_W      = 16,
    parameter int ADDR_BYTES = 2,
    parameter int DEV_SIZE   = 65536,
    parameter int CLK_DIV    = 2,
    parameter int CS_GAP     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_data,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              done,
    output logic [LEN_W-1:0]  done_count,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n
);
    localparam int GAP_W = (CS_GAP > 1) ? $clog2(CS_GAP + 1) : 1;

    fram_state_e       state, nstate;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  rem;
    logic              write_q;
    logic [1:0]        aidx;
    logic [GAP_W-1:0]  gap_cnt;
    logic              pend;

    logic              sh_start, sh_idle, sh_done;
    logic [7:0]        sh_tx, sh_rx;
    logic [7:0]        opcode, abyte;
    logic              accept, can_launch;

    logic              cs_n_q, busy_q, done_q, rd_valid_q;
    logic [7:0]        rd_data_q;
    logic [LEN_W-1:0]  done_count_q;

    fram_cmd_build #(
        .ADDR_W    (ADDR_W),
        .ADDR_BYTES(ADDR_BYTES),
        .DEV_SIZE  (DEV_SIZE)
    ) u_cmd (
        .addr    (addr_q),
        .is_write(write_q),
        .idx     (aidx),
        .opcode  (opcode),
        .abyte   (abyte)
    );

    fram_byte_shift #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .start(sh_start),
        .tx   (sh_tx),
        .miso (spi_miso),
        .idle (sh_idle),
        .done (sh_done),
        .sclk (spi_sclk),
        .mosi (spi_mosi),
        .rx   (sh_rx)
    );

    assign req_ready  = (state == ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign can_launch = sh_idle && !pend;
    assign wr_ready   = (state == ST_WDATA) && can_launch;

    always_comb begin
        sh_start = 1'b0;
        sh_tx    = 8'h00;
        unique case (state)
            ST_WREN:  begin sh_start = can_launch; sh_tx = OP_WREN; end
            ST_OPC:   begin sh_start = can_launch; sh_tx = opcode;  end
            ST_ADDR:  begin sh_start = can_launch; sh_tx = abyte;   end
            ST_WDATA: begin sh_start = can_launch && wr_valid; sh_tx = wr_data; end
            ST_RDATA: begin sh_start = can_launch; sh_tx = 8'h00;   end
            default:  begin sh_start = 1'b0; sh_tx = 8'h00; end
        endcase
    end

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (req_len == '0)  nstate = ST_DONE;
                    else if (req_write) nstate = ST_WREN;
                    else                nstate = ST_OPC;
                end
            end
            ST_WREN:  if (sh_done) nstate = ST_GAP;
            ST_GAP:   if (gap_cnt == GAP_W'(CS_GAP - 1)) nstate = ST_OPC;
            ST_OPC:   if (sh_done) nstate = ST_ADDR;
            ST_ADDR:  if (sh_done && aidx == 2'd0) nstate = write_q ? ST_WDATA : ST_RDATA;
            ST_WDATA: if (sh_done && rem == LEN_W'(1)) nstate = ST_DONE;
            ST_RDATA: if (sh_done && rem == LEN_W'(1)) nstate = ST_DONE;
            ST_DONE:  nstate = ST_IDLE;
            default:  nstate = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // transfer context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            len_q   <= '0;
            rem     <= '0;
            write_q <= 1'b0;
            aidx    <= '0;
            gap_cnt <= '0;
            pend    <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                len_q   <= req_len;
                rem     <= req_len;
                write_q <= req_write;
                aidx    <= 2'(ADDR_BYTES - 1);
            end
            gap_cnt <= (state == ST_GAP) ? gap_cnt + 1'b1 : '0;
            if (sh_start)     pend <= 1'b1;
            else if (sh_done) pend <= 1'b0;
            if (sh_done && state == ST_ADDR) aidx <= aidx - 1'b1;
            if (sh_done && (state == ST_WDATA || state == ST_RDATA)) rem <= rem - 1'b1;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q       <= 1'b1;
            busy_q       <= 1'b0;
            done_q       <= 1'b0;
            done_count_q <= '0;
            rd_valid_q   <= 1'b0;
            rd_data_q    <= '0;
        end else begin
            cs_n_q <= !(nstate == ST_WREN || nstate == ST_OPC || nstate == ST_ADDR ||
                        nstate == ST_WDATA || nstate == ST_RDATA);
            busy_q <= (nstate != ST_IDLE);
            done_q <= (nstate == ST_DONE);
            if (nstate == ST_DONE) done_count_q <= (state == ST_IDLE) ? '0 : len_q;
            rd_valid_q <= (state == ST_RDATA) && sh_done;
            if ((state == ST_RDATA) && sh_done) rd_data_q <= sh_rx;
        end
    end

    assign spi_cs_n   = cs_n_q;
    assign busy       = busy_q;
    assign done       = done_q;
    assign done_count = done_count_q;
    assign rd_valid   = rd_valid_q;
    assign rd_data    = rd_data_q;

    // run length of chip-select-high cycles, used by the gap check
    logic [GAP_W-1:0] cs_hi_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cs_hi_run <= '0;
        else if (!spi_cs_n)                  cs_hi_run <= '0;
        else if (cs_hi_run != GAP_W'(CS_GAP)) cs_hi_run <= cs_hi_run + 1'b1;
    end

    // R1: chip select stays high whenever no transfer runs
    a_r1_idle_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n);
    // R2: the serial clock stays low outside a chip-select window
    a_r2_sclk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);
    // R4: the write window opens only after the full idle gap
    a_r4_gap_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(spi_cs_n) && write_q && state == ST_OPC) |-> (cs_hi_run == GAP_W'(CS_GAP)));
    // R8: acceptance raises busy and closes the request port
    a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (busy && !req_ready));
    // R9: busy drops right after the done pulse
    a_r9_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R11: no byte starts in the write phase without offered data
    a_r11_wait_data: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA && !wr_valid) |-> !sh_start);
endmodule

// File: tb/fram_link_tb.sv
module fram_dev_model (
    input  logic clk,
    input  logic clr,
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    output logic miso
);
    logic [7:0] win_data [0:3][0:15];
    int win_len [0:3];
    int win_cnt, gap_min, per_min, per_max, rises, cyc;
    int hi_cnt, bitc, bytec, last_rise, obit, obyte;
    logic pcs = 1'b1;
    logic psclk = 1'b0;
    logic [7:0] sh, tmp;

    function automatic logic [7:0] pat(input int k);
        return 8'((k * 37 + 5) & 255);
    endfunction

    always @(posedge clk) begin
        if (clr) begin
            win_cnt = 0; gap_min = 9999; per_min = 9999; per_max = 0; rises = 0;
            hi_cnt = 0; bitc = 0; bytec = 0; last_rise = -100; cyc = 0;
            obit = 0; obyte = 0; sh = 8'h00;
            miso <= 1'b0;
        end else begin
            cyc++;
            if (cs_n) hi_cnt = pcs ? hi_cnt + 1 : 1;
            if (pcs && !cs_n) begin
                bitc = 0; bytec = 0; obit = 0; obyte = 0;
                tmp = pat(0);
                miso <= tmp[7];
                if (win_cnt > 0 && hi_cnt < gap_min) gap_min = hi_cnt;
            end
            if (!cs_n && sclk && !psclk) begin
                rises++;
                if (bitc != 0) begin
                    if (cyc - last_rise < per_min) per_min = cyc - last_rise;
                    if (cyc - last_rise > per_max) per_max = cyc - last_rise;
                end
                last_rise = cyc;
                sh = {sh[6:0], mosi};
                bitc++;
                if (bitc == 8) begin
                    if (win_cnt < 4 && bytec < 16) win_data[win_cnt][bytec] = sh;
                    bytec++;
                    bitc = 0;
                end
            end
            if (!cs_n && !sclk && psclk) begin
                obit++;
                if (obit == 8) begin obit = 0; obyte++; end
                tmp = pat(obyte);
                miso <= tmp[7 - obit];
            end
            if (!pcs && cs_n) begin
                if (win_cnt < 4) win_len[win_cnt] = bytec;
                win_cnt++;
            end
        end
        pcs = cs_n;
        psclk = sclk;
    end
endmodule

module fram_link_tb;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, clr, sel;
    logic rv, rw, feed_en;
    logic [23:0] ra;
    logic [15:0] rl;
    logic [7:0] dbase, wd;
    int total = 0, bad = 0;
    int feed_idx, rd_n, done_hits, done_val;
    logic [7:0] rd_buf [0:31];

    logic a_rr, a_wr, a_rdv, a_busy, a_done, a_sclk, a_mosi, a_miso, a_cs;
    logic b_rr, b_wr, b_rdv, b_busy, b_done, b_sclk, b_mosi, b_miso, b_cs;
    logic [7:0] a_rd, b_rd;
    logic [15:0] a_dc, b_dc;

    assign wd = dbase + 8'(feed_idx);

    fram_link #(.ADDR_W(24), .LEN_W(16), .ADDR_BYTES(2), .DEV_SIZE(65536),
                .CLK_DIV(2), .CS_GAP(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(rv && !sel), .req_ready(a_rr),
        .req_write(rw), .req_addr(ra), .req_len(rl),
        .wr_valid(feed_en && !sel), .wr_ready(a_wr), .wr_data(wd),
        .rd_valid(a_rdv), .rd_data(a_rd), .busy(a_busy), .done(a_done),
        .done_count(a_dc), .spi_sclk(a_sclk), .spi_mosi(a_mosi),
        .spi_miso(a_miso), .spi_cs_n(a_cs));

    fram_link #(.ADDR_W(24), .LEN_W(16), .ADDR_BYTES(1), .DEV_SIZE(512),
                .CLK_DIV(2), .CS_GAP(3)) u_dut_cmp (
        .clk(clk), .rst_n(rst_n), .req_valid(rv && sel), .req_ready(b_rr),
        .req_write(rw), .req_addr(ra), .req_len(rl),
        .wr_valid(feed_en && sel), .wr_ready(b_wr), .wr_data(wd),
        .rd_valid(b_rdv), .rd_data(b_rd), .busy(b_busy), .done(b_done),
        .done_count(b_dc), .spi_sclk(b_sclk), .spi_mosi(b_mosi),
        .spi_miso(b_miso), .spi_cs_n(b_cs));

    fram_dev_model ma (.clk(clk), .clr(clr), .cs_n(a_cs), .sclk(a_sclk), .mosi(a_mosi), .miso(a_miso));
    fram_dev_model mb (.clk(clk), .clr(clr), .cs_n(b_cs), .sclk(b_sclk), .mosi(b_mosi), .miso(b_miso));

    wire m_busy = sel ? b_busy : a_busy;
    wire m_rr   = sel ? b_rr   : a_rr;
    wire m_cs   = sel ? b_cs   : a_cs;
    wire m_sclk = sel ? b_sclk : a_sclk;

    always @(posedge clk) begin
        if (clr) begin
            feed_idx <= 0; rd_n <= 0; done_hits <= 0; done_val <= 0;
        end else begin
            if (feed_en && (sel ? b_wr : a_wr)) feed_idx <= feed_idx + 1;
            if (sel ? b_rdv : a_rdv) begin
                rd_buf[rd_n[4:0]] <= sel ? b_rd : a_rd;
                rd_n <= rd_n + 1;
            end
            if (sel ? b_done : a_done) begin
                done_hits <= done_hits + 1;
                done_val  <= int'(sel ? b_dc : a_dc);
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    function automatic int wbyte(input int w, input int i);
        return sel ? int'(mb.win_data[w][i]) : int'(ma.win_data[w][i]);
    endfunction
    function automatic int wlen(input int w);
        return sel ? mb.win_len[w] : ma.win_len[w];
    endfunction
    function automatic int wcnt();
        return sel ? mb.win_cnt : ma.win_cnt;
    endfunction
    function automatic int pat(input int k);
        return (k * 37 + 5) & 255;
    endfunction

    task automatic run(input bit wr, input int addr, input int len, input bit stall);
        int na, op, t, r0;
        na = sel ? 1 : 2;
        clr = 1'b1;
        @(negedge clk);
        @(negedge clk);
        clr = 1'b0;
        feed_en = !stall;
        dbase = 8'(addr) ^ 8'h5A;
        rw = wr; ra = 24'(addr); rl = 16'(len); rv = 1'b1;
        @(negedge clk);
        rv = 1'b0;
        chk("R8", "busy after accept", int'(m_busy), 1);
        chk("R8", "ready after accept", int'(m_rr), 0);
        if (stall) begin
            repeat (250) @(negedge clk);
            r0 = sel ? mb.rises : ma.rises;
            repeat (40) @(negedge clk);
            chk("R11", "clock edges while data withheld", (sel ? mb.rises : ma.rises) - r0, 0);
            chk("R11", "cs held low while data withheld", int'(m_cs), 0);
            chk("R11", "bytes taken while data withheld", feed_idx, 0);
            feed_en = 1'b1;
        end
        t = 0;
        while (done_hits == 0 && t < 4000) begin @(negedge clk); t++; end
        @(negedge clk);
        chk("R9", "done pulses", done_hits, 1);
        chk("R9", "done_count", done_val, len);
        chk("R9", "busy after done", int'(m_busy), 0);
        chk("R1", "cs high after transfer", int'(m_cs), 1);
        feed_en = 1'b0;
        op = (wr ? 2 : 3) | ((sel && addr > 255) ? 8 : 0);
        if (len == 0) begin
            chk("R10", "windows for zero count", wcnt(), 0);
        end else if (wr) begin
            chk("R3", "window count of a write", wcnt(), 2);
            chk("R3", "write-enable window length", wlen(0), 1);
            chk("R3", "write-enable byte", wbyte(0, 0), 6);
            chk("R4", "gap not shorter than CS_GAP", int'((sel ? mb.gap_min : ma.gap_min) >= 3), 1);
            chk("R5", "write window length", wlen(1), 1 + na + len);
            chk("R7", "write opcode", wbyte(1, 0), op);
            for (int i = 0; i < na; i++)
                chk("R5", "address byte", wbyte(1, 1 + i), (addr >> (8 * (na - 1 - i))) & 255);
            for (int i = 0; i < len; i++)
                chk("R5", "data byte", wbyte(1, 1 + na + i), (int'(dbase) + i) & 255);
        end else begin
            chk("R6", "window count of a read", wcnt(), 1);
            chk("R6", "read window length", wlen(0), 1 + na + len);
            chk("R7", "read opcode", wbyte(0, 0), op);
            for (int i = 0; i < na; i++)
                chk("R6", "address byte", wbyte(0, 1 + i), (addr >> (8 * (na - 1 - i))) & 255);
            chk("R6", "read bytes delivered", rd_n, len);
            for (int i = 0; i < len; i++)
                chk("R6", "read byte value", int'(rd_buf[i]), pat(1 + na + i));
        end
        if (len > 0) begin
            chk("R2", "min rising-edge spacing", sel ? mb.per_min : ma.per_min, 4);
            chk("R2", "max rising-edge spacing", sel ? mb.per_max : ma.per_max, 4);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int addrs_a [3];
        int addrs_b [4];
        addrs_a = '{0, 'h1234, 'hABCDEF};
        addrs_b = '{0, 'hFF, 'h100, 'h1FF};
        rst_n = 1'b0; clr = 1'b1; sel = 1'b0; rv = 1'b0; rw = 1'b0;
        ra = '0; rl = '0; feed_en = 1'b0; dbase = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "cs after reset", int'(a_cs), 1);
        chk("R1", "sclk after reset", int'(a_sclk), 0);
        chk("R1", "busy after reset", int'(a_busy), 0);
        chk("R1", "done after reset", int'(a_done), 0);
        chk("R1", "ready after reset", int'(a_rr), 1);
        chk("R1", "compact cs after reset", int'(b_cs), 1);
        chk("R1", "compact busy after reset", int'(b_busy), 0);
        for (int ai = 0; ai < 3; ai++)
            for (int len = 0; len < 6; len++) begin
                run(1'b1, addrs_a[ai], len, 1'b0);
                run(1'b0, addrs_a[ai], len, 1'b0);
            end
        run(1'b1, 'h0042, 3, 1'b1);
        sel = 1'b1;
        for (int ai = 0; ai < 4; ai++)
            for (int len = 0; len < 4; len++) begin
                run(1'b1, addrs_b[ai], len, 1'b0);
                run(1'b0, addrs_b[ai], len, 1'b0);
            end
        finish_run();
    end
endmodule